// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block collects interrupt requests from a set of hardware sources, which may be pins from outside the chip or lines from peripherals on the same die. It also holds fifteen software-raised request bits, one per priority level. Each hardware source is tied to a fixed level through a parameter table, and several sources may share a level. A rising edge on a source line latches a pending bit. That bit contributes to the output only while the source's enable bit is set. The processor sees one registered 4-bit value: the highest level currently requested, or zero when nothing is requested.

Software drives a small write/read port. Three locations each serve one state vector. A location is read back combinationally, and its paired write address either sets or clears bits by writing ones. Pending hardware bits are cleared by writing ones; they cannot be set from the port. Clearing and priority resolution happen inside the block, while trap dispatch belongs to the processor.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, irqLevel is 0 and the enable, pending and software vectors read back as 0.
- R2: A write to address 0 sets the enable bits given as ones in regWrData, and a write to address 1 clears them. Address 0 reads back the enable vector, zero-extended.
- R3: A 0-to-1 change seen on hwReq[i] between two rising clock edges sets pending bit i, which is read back at address 2. A line held high does not set the bit again once it has been cleared.
- R4: A write of ones to address 2 clears those pending bits. If a rising edge on the same source arrives in the same cycle, the bit stays set.
- R5: A write to address 3 sets software bits and a write to address 4 clears them. Software bit k requests level k+1. Address 3 reads back the software vector.
- R6: irqLevel equals the highest level among the sources that are both pending and enabled and the set software bits, and it is 0 when none of these exist. The default table maps sources 0 to 7 onto levels 2, 4, 4, 7, 9, 11, 13, 15, so sources 1 and 2 share level 4.
- R7: irqLevel is registered. It reflects the state vectors as they stood one clock earlier.
- R8: A pending source whose enable bit is clear keeps its pending bit but adds nothing to irqLevel. It appears on irqLevel one cycle after the enable bit is set.
- R9: Writes to addresses 5 to 7 change no state, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| hwReq | input | NUM_SRC | Hardware request lines, edge-sensitive |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register address for both read and write |
| regWrData | input | DATA_W | Write data; a one selects a bit |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| irqLevel | output | LVL_W | Encoded request level; 0 means none |

## Verification
The assertions assume that hwReq and the port inputs are synchronous to clk and hold steady across each rising edge. They also assume that the request history starts from all-low at the end of reset, so that a line already high at reset release does not count as an edge. The bench drives every input one time unit after a rising edge and holds hwReq low throughout reset. Its random phase changes the lines only at those drive points, and it writes to all eight addresses, including the unused ones.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam logic [2:0] ADDR_MASK_SET = 3'd0;
  localparam logic [2:0] ADDR_MASK_CLR = 3'd1;
  localparam logic [2:0] ADDR_PEND_CLR = 3'd2;
  localparam logic [2:0] ADDR_SOFT_SET = 3'd3;
  localparam logic [2:0] ADDR_SOFT_CLR = 3'd4;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_PEND = 2'd2,
    RD_SOFT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   maskSet;
    logic   maskClr;
    logic   pendClr;
    logic   softSet;
    logic   softClr;
    rdSel_e rdSel;
  } irqStrobe_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  output irqStrobe_t strobe
);

  always_comb begin
    strobe = '{maskSet: 1'b0, maskClr: 1'b0, pendClr: 1'b0,
               softSet: 1'b0, softClr: 1'b0, rdSel: RD_NONE};
    case (regAddr)
      ADDR_MASK_SET: begin
        strobe.maskSet = regWrEn;
        strobe.rdSel   = RD_MASK;
      end
      ADDR_MASK_CLR: strobe.maskClr = regWrEn;
      ADDR_PEND_CLR: begin
        strobe.pendClr = regWrEn;
        strobe.rdSel   = RD_PEND;
      end
      ADDR_SOFT_SET: begin
        strobe.softSet = regWrEn;
        strobe.rdSel   = RD_SOFT;
      end
      ADDR_SOFT_CLR: strobe.softClr = regWrEn;
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVELS = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       hwReq,
  input  irqStrobe_t               strobe,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [LVL_W-1:0]         irqLevel,
  output logic [NUM_SRC-1:0]       maskVec,
  output logic [NUM_SRC-1:0]       pendVec,
  output logic [(2**LVL_W)-2:0]    softVec
);

  localparam int NUM_LVL = (2 ** LVL_W) - 1;
  localparam int HIT_W   = NUM_LVL + 1;

  logic [NUM_SRC-1:0] hwPrev;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] activeVec;
  logic [HIT_W-1:0]   srcHit [NUM_SRC];
  logic [HIT_W-1:0]   levelHit;
  logic [LVL_W-1:0]   topLevel;

  assign riseVec   = hwReq & ~hwPrev;
  assign activeVec = pendVec & maskVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwPrev  <= '0;
      maskVec <= '0;
      pendVec <= '0;
      softVec <= '0;
    end else begin
      hwPrev <= hwReq;
      if (strobe.maskSet) maskVec <= maskVec | wrData[NUM_SRC-1:0];
      else if (strobe.maskClr) maskVec <= maskVec & ~wrData[NUM_SRC-1:0];
      if (strobe.pendClr) pendVec <= (pendVec & ~wrData[NUM_SRC-1:0]) | riseVec;
      else pendVec <= pendVec | riseVec;
      if (strobe.softSet) softVec <= softVec | wrData[NUM_LVL-1:0];
      else if (strobe.softClr) softVec <= softVec & ~wrData[NUM_LVL-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [LVL_W-1:0] SrcLvl = SRC_LEVELS[g*LVL_W +: LVL_W];
    assign srcHit[g] = activeVec[g] ? (HIT_W'(1) << SrcLvl) : '0;
  end

  always_comb begin
    levelHit = {softVec, 1'b0};
    for (int s = 0; s < NUM_SRC; s++) levelHit = levelHit | srcHit[s];
    topLevel = '0;
    for (int l = 1; l < HIT_W; l++) begin
      if (levelHit[l]) topLevel = LVL_W'(l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqLevel <= '0;
    else       irqLevel <= topLevel;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_MASK: rdData = DATA_W'(maskVec);
      RD_PEND: rdData = DATA_W'(pendVec);
      RD_SOFT: rdData = DATA_W'(softVec);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVELS =
    {4'd15, 4'd13, 4'd11, 4'd9, 4'd7, 4'd4, 4'd4, 4'd2}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [LVL_W-1:0]   irqLevel
);

  localparam int NUM_LVL = (2 ** LVL_W) - 1;

  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_LVL-1:0] softVec;

  irq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .LVL_W      (LVL_W),
    .DATA_W     (DATA_W),
    .SRC_LEVELS (SRC_LEVELS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hwReq    (hwReq),
    .strobe   (strobe),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqLevel (irqLevel),
    .maskVec  (maskVec),
    .pendVec  (pendVec),
    .softVec  (softVec)
  );

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_SRC-1:0]      hwReq,
  input logic                    regWrEn,
  input logic [2:0]              regAddr,
  input logic [DATA_W-1:0]       regWrData,
  input logic [LVL_W-1:0]        irqLevel,
  input logic [NUM_SRC-1:0]      maskVec,
  input logic [NUM_SRC-1:0]      pendVec,
  input logic [(2**LVL_W)-2:0]   softVec
);

  localparam int NUM_LVL = (2 ** LVL_W) - 1;

  logic [NUM_SRC-1:0] seenPrev;
  logic [NUM_SRC-1:0] edgeSeen;
  logic [LVL_W-1:0]   softTop;

  always_ff @(posedge clk) begin
    if (!rstN) seenPrev <= '0;
    else       seenPrev <= hwReq;
  end

  assign edgeSeen = hwReq & ~seenPrev;

  always_comb begin
    softTop = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (softVec[k]) softTop = LVL_W'(k + 1);
    end
  end

  // R2
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0) |=>
      ((maskVec & $past(regWrData[NUM_SRC-1:0])) == $past(regWrData[NUM_SRC-1:0])));

  // R3
  p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen != '0) |=> ((pendVec & $past(edgeSeen)) == $past(edgeSeen)));

  // R4
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd2) |=> ((pendVec & $past(pendVec)) == $past(pendVec)));

  // R5
  p_soft_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (softVec != '0) |=> (irqLevel >= $past(softTop)));

  // R6
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & maskVec) == '0 && softVec == '0) |=> (irqLevel == '0));

endmodule

bind irq_prio_ctrl irq_prio_checker #(
  .NUM_SRC (NUM_SRC),
  .LVL_W   (LVL_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hwReq     (hwReq),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .irqLevel  (irqLevel),
  .maskVec   (maskVec),
  .pendVec   (pendVec),
  .softVec   (softVec)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

  localparam int NS = 8;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int LVL [NS] = '{2, 4, 4, 7, 9, 11, 13, 15};

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] hwReq;
  logic          regWrEn;
  logic [2:0]    regAddr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic [LW-1:0] irqLevel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit [NS-1:0] mMask, mPend, mHwPrev;
  bit [14:0]   mSoft;
  int          mLevel;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hwReq     (hwReq),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqLevel  (irqLevel)
  );

  function automatic int modelTop();
    int best = 0;
    for (int k = 0; k < 15; k++) if (mSoft[k]) best = k + 1;
    for (int s = 0; s < NS; s++) if (mPend[s] && mMask[s] && LVL[s] > best) best = LVL[s];
    return best;
  endfunction

  function automatic int modelRead(input logic [2:0] a);
    case (a)
      3'd0: return int'(mMask);
      3'd2: return int'(mPend);
      3'd3: return int'(mSoft);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = '0; mPend = '0; mSoft = '0; mHwPrev = '0; mLevel = 0;
    end else begin
      int nextLevel;
      bit [NS-1:0] rise;
      nextLevel = modelTop();
      rise = hwReq & ~mHwPrev;
      mHwPrev = hwReq;
      if (regWrEn) begin
        case (regAddr)
          3'd0: mMask = mMask | regWrData[NS-1:0];
          3'd1: mMask = mMask & ~regWrData[NS-1:0];
          3'd2: mPend = mPend & ~regWrData[NS-1:0];
          3'd3: mSoft = mSoft | regWrData[14:0];
          3'd4: mSoft = mSoft & ~regWrData[14:0];
          default: ;
        endcase
      end
      mPend = mPend | rise;
      mLevel = nextLevel;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    check("R7", int'(irqLevel), mLevel);
    check("R2", int'(regRdData), modelRead(regAddr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input int exp);
    regAddr = a;
    #1;
    check(tag, int'(regRdData), exp);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hwReq = '0; regWrEn = 1'b0; regAddr = 3'd0; regWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(irqLevel), 0);
    rd(3'd0, "R1", 0);
    rd(3'd2, "R1", 0);
    rd(3'd3, "R1", 0);
    rstN = 1'b1;
    step();
    check("R1", int'(irqLevel), 0);

    // masked source keeps pending state
    hwReq[3] = 1'b1;
    step();
    rd(3'd2, "R3", 8);
    step();
    check("R8", int'(irqLevel), 0);
    wr(3'd0, 16'h0008);
    check("R8", int'(irqLevel), 0);
    step();
    check("R8", int'(irqLevel), 7);

    // software level above hardware
    wr(3'd3, 16'h0200);
    step();
    check("R5", int'(irqLevel), 10);

    // highest source
    hwReq[7] = 1'b1;
    wr(3'd0, 16'h0080);
    step();
    check("R6", int'(irqLevel), 15);

    // clear pending, held line does not relatch
    wr(3'd2, 16'h0080);
    step();
    check("R4", int'(irqLevel), 10);
    step();
    rd(3'd2, "R3", 8);

    wr(3'd4, 16'h0200);
    step();
    check("R5", int'(irqLevel), 7);

    // two sources sharing level 4
    wr(3'd0, 16'h0006);
    hwReq[1] = 1'b1; hwReq[2] = 1'b1;
    step();
    step();
    check("R6", int'(irqLevel), 7);
    wr(3'd2, 16'h0008);
    step();
    check("R6", int'(irqLevel), 4);
    wr(3'd2, 16'h0002);
    step();
    check("R6", int'(irqLevel), 4);
    wr(3'd2, 16'h0004);
    step();
    check("R6", int'(irqLevel), 0);

    // edge and clear in the same cycle
    hwReq[1] = 1'b0;
    step();
    hwReq[1] = 1'b1;
    wr(3'd2, 16'h0002);
    rd(3'd2, "R4", 2);

    // unused addresses
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd0, "R9", 8'h8E);
    rd(3'd3, "R9", 0);
    rd(3'd6, "R9", 0);
    wr(3'd1, 16'h00FF);
    rd(3'd0, "R2", 0);

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      hwReq = NS'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        regWrEn = 1'b1;
        regAddr = 3'($urandom_range(0, 7));
        regWrData = DW'($urandom);
      end else begin
        regWrEn = 1'b0;
        regAddr = 3'($urandom_range(0, 7));
      end
      step();
    end
    regWrEn = 1'b0;
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule